// File: doc/BRIEF.md
# Per-Pin Interrupt Sense Bank

This block holds a bank of identical per-pin detectors for a general-purpose I/O controller. Each detector looks at a pin's current sampled level and its previous sampled level. It uses a two-bit sense code and a per-pin both-edges override to decide whether the pin should request that its interrupt status bit be set in this cycle. The result is a vector of set requests, one bit per pin, which the surrounding controller ORs into its status register. Status storage, masking and bus access sit outside this block.

Evaluation runs on every clock, and the request vector is registered, so a request appears one clock edge after the inputs that cause it. Pins configured as outputs never request. A re-evaluate strobe lets software-driven configuration changes re-trigger level-sensitive pins. It can never create an edge for the edge modes. A parameter chooses how level-sensitive pins behave. In one variant they request on every cycle while the level is active. In the other they request only when the strobe is high or when their level has just changed.

Top module: `irq_sense_bank`

## Requirements
- R1: While `rst_n` is low, `set_req` is all zeros, and it clears asynchronously when reset asserts.
- R2: A pin whose `pin_dir` bit is 1 (output) never produces a request, whatever its code, override or levels.
- R3: Pin n uses `sense_cfg[2n+1:2n]`. Code 00 requests when the current level is 0, and code 01 requests when it is 1. The request appears in `set_req` one clock edge after the inputs.
- R4: Code 10 requests when the previous level is 0 and the current level is 1 (rising edge).
- R5: Code 11 requests when the previous level is 1 and the current level is 0 (falling edge).
- R6: When a pin's `both_sel` bit is 1, its code is ignored and any difference between the previous and current levels requests.
- R7: In the edge codes and in override mode, no request is made when the current level equals the previous level, even with `reeval` high.
- R8: With `LVL_EVERY_CLK`=1, a level-sensitive pin requests on every cycle its level matches the polarity bit, whether or not the level changed and whether or not `reeval` is high.
- R9: With `LVL_EVERY_CLK`=0, a level-sensitive pin with a matching level requests only when `reeval` is high or its level changed in that cycle.
- R10: Each pin's request depends only on that pin's own level, direction, code and override bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_now | input | NPINS | Current synchronised pin levels |
| pin_prev | input | NPINS | Previous sampled pin levels |
| pin_dir | input | NPINS | Direction per pin, 1 = output |
| sense_cfg | input | 2*NPINS | Two-bit sense code per pin, pin n at bits 2n+1:2n |
| both_sel | input | NPINS | Per-pin both-edges override |
| reeval | input | 1 | Re-evaluate strobe |
| set_req | output | NPINS | Registered per-pin status set requests |

## Verification
The bench builds two instances. One uses the full 32-pin width with level pins that request on every cycle. The other uses 4 pins with level pins gated by the strobe or by a level change. Each table vector is driven identically into every pin, so every generated cell is checked against every code and override combination. The two instances together show where the two level variants differ: persistence without a strobe, and re-triggering by the strobe. A mixed-configuration vector confirms that the pins stay independent.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;
   typedef enum logic [1:0] {
      SNS_LOW  = 2'b00,
      SNS_HIGH = 2'b01,
      SNS_RISE = 2'b10,
      SNS_FALL = 2'b11
   } sense_e;
endpackage

// File: rtl/pin_sense_cell.sv
module pin_sense_cell
   import irq_sense_pkg::*;
#(
   parameter bit LVL_EVERY_CLK = 1'b1
) (
   input  logic       lvl_now,
   input  logic       lvl_prev,
   input  logic       is_out,
   input  logic [1:0] code,
   input  logic       both,
   input  logic       reeval,
   output logic       hit
);
   logic changed;
   logic lvl_gate;
   sense_e mode;

   assign changed = lvl_now ^ lvl_prev;
   assign mode    = sense_e'(code);

   generate
      if (LVL_EVERY_CLK) begin : g_lvl_cont
         assign lvl_gate = 1'b1;
      end else begin : g_lvl_gated
         assign lvl_gate = reeval | changed;
      end
   endgenerate

   always_comb begin
      hit = 1'b0;
      if (!is_out) begin
         if (both) begin
            hit = changed;
         end else begin
            unique case (mode)
               SNS_LOW:  hit = ~lvl_now & lvl_gate;
               SNS_HIGH: hit = lvl_now & lvl_gate;
               SNS_RISE: hit = changed & lvl_now;
               SNS_FALL: hit = changed & ~lvl_now;
               default:  hit = 1'b0;
            endcase
         end
      end
   end
endmodule

// File: rtl/req_stage.sv
module req_stage #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end
endmodule

// File: rtl/irq_sense_bank.sv
module irq_sense_bank #(
   parameter int NPINS         = 32,
   parameter bit LVL_EVERY_CLK = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NPINS-1:0]     pin_now,
   input  logic [NPINS-1:0]     pin_prev,
   input  logic [NPINS-1:0]     pin_dir,
   input  logic [2*NPINS-1:0]   sense_cfg,
   input  logic [NPINS-1:0]     both_sel,
   input  logic                 reeval,
   output logic [NPINS-1:0]     set_req
);
   localparam int CFG_W = 2 * NPINS;

   generate
      if (NPINS < 1 || NPINS > 64) begin : g_bad_npins
         $error("irq_sense_bank: NPINS must be 1..64");
      end
      if (CFG_W != 2 * NPINS) begin : g_bad_cfg
         $error("irq_sense_bank: config width mismatch");
      end
   endgenerate

   logic [NPINS-1:0] hit_d;
   logic [NPINS-1:0] edge_mode;
   logic [NPINS-1:0] pol;

   generate
      for (genvar g = 0; g < NPINS; g++) begin : g_pin
         pin_sense_cell #(.LVL_EVERY_CLK(LVL_EVERY_CLK)) u_cell (
            .lvl_now  (pin_now[g]),
            .lvl_prev (pin_prev[g]),
            .is_out   (pin_dir[g]),
            .code     (sense_cfg[2*g+1:2*g]),
            .both     (both_sel[g]),
            .reeval   (reeval),
            .hit      (hit_d[g])
         );
         assign edge_mode[g] = both_sel[g] | sense_cfg[2*g+1];
         assign pol[g]       = sense_cfg[2*g];
      end
   endgenerate

   req_stage #(.W(NPINS)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (hit_d),
      .q     (set_req)
   );

   AST_OUTPUT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((set_req & $past(pin_dir)) == '0)); // R2

   AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((set_req & $past(edge_mode) & ~$past(pin_now ^ pin_prev)) == '0)); // R7

   AST_LEVEL_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((set_req & ~$past(edge_mode) & ($past(pin_now) ^ $past(pol))) == '0)); // R3

   AST_BOTH_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((~set_req & $past(both_sel & ~pin_dir & (pin_now ^ pin_prev))) == '0)); // R6

   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |-> (set_req == '0)); // R1
endmodule

// File: tb/test_irq_sense_bank.sv
module test_irq_sense_bank;
   localparam int CLK_PERIOD = 10;
   localparam int NA = 32;
   localparam int NB = 4;
   localparam int NVEC = 18;

   // {dir, both, code[1:0], prev, now, strobe, expA, expB}
   localparam logic [8:0] VEC [NVEC] = '{
      9'b1_1_01_0_1_0_0_0,  // R2 output pin with override
      9'b1_0_01_1_1_1_0_0,  // R2 output pin level high
      9'b0_0_00_0_0_0_1_0,  // R3 low level, R9 no strobe no change
      9'b0_0_00_1_0_0_1_1,  // R3 R9 change into low
      9'b0_0_00_0_1_0_0_0,  // R3 high when low wanted
      9'b0_0_01_1_1_0_1_0,  // R8 persists, R9 gated
      9'b0_0_01_1_1_1_1_1,  // R8 R9 strobe re-triggers
      9'b0_0_01_0_0_1_0_0,  // R3 inactive level
      9'b0_0_10_0_1_0_1_1,  // R4 rising
      9'b0_0_10_1_0_0_0_0,  // R4 falling ignored
      9'b0_0_10_1_1_1_0_0,  // R7 strobe no edge
      9'b0_0_11_1_0_0_1_1,  // R5 falling
      9'b0_0_11_0_1_0_0_0,  // R5 rising ignored
      9'b0_0_11_0_0_1_0_0,  // R7 strobe no edge
      9'b0_1_10_0_1_0_1_1,  // R6 rise
      9'b0_1_10_1_0_0_1_1,  // R6 fall overrides rising code
      9'b0_1_01_1_1_1_0_0,  // R7 override, no change
      9'b0_1_00_0_0_0_0_0   // R6 override beats level low
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NA-1:0]   pin_now = '0, pin_prev = '0, pin_dir = '0, both_sel = '0;
   logic [2*NA-1:0] sense_cfg = '0;
   logic            reeval = 1'b0;
   logic [NA-1:0]   set_req_a;
   logic [NB-1:0]   set_req_b;
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_sense_bank #(.NPINS(NA), .LVL_EVERY_CLK(1'b1)) i_irq_sense_bank (
      .clk(clk), .rst_n(rst_n), .pin_now(pin_now), .pin_prev(pin_prev),
      .pin_dir(pin_dir), .sense_cfg(sense_cfg), .both_sel(both_sel),
      .reeval(reeval), .set_req(set_req_a));

   irq_sense_bank #(.NPINS(NB), .LVL_EVERY_CLK(1'b0)) i_irq_sense_bank_b (
      .clk(clk), .rst_n(rst_n), .pin_now(pin_now[NB-1:0]), .pin_prev(pin_prev[NB-1:0]),
      .pin_dir(pin_dir[NB-1:0]), .sense_cfg(sense_cfg[2*NB-1:0]), .both_sel(both_sel[NB-1:0]),
      .reeval(reeval), .set_req(set_req_b));

   task automatic check(input string req, input logic [NA-1:0] act, input logic [NA-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      check("R1 reset A", set_req_a, '0);
      check("R1 reset B", {{(NA-NB){1'b0}}, set_req_b}, '0);
      rst_n = 1'b1;

      for (int v = 0; v < NVEC; v++) begin
         pin_dir   = {NA{VEC[v][8]}};
         both_sel  = {NA{VEC[v][7]}};
         sense_cfg = {NA{VEC[v][6:5]}};
         pin_prev  = {NA{VEC[v][4]}};
         pin_now   = {NA{VEC[v][3]}};
         reeval    = VEC[v][2];
         @(posedge clk);
         @(negedge clk);
         check($sformatf("R2-R9 vec%0d A", v), set_req_a, {NA{VEC[v][1]}});
         check($sformatf("R2-R9 vec%0d B", v), {{(NA-NB){1'b0}}, set_req_b},
               {{(NA-NB){1'b0}}, {NB{VEC[v][0]}}});
      end

      // R10 mixed per-pin configuration
      pin_dir   = 32'h0000_0002;
      both_sel  = '0;
      sense_cfg = {NA{2'b01}};
      sense_cfg[1:0] = 2'b10;
      sense_cfg[5:4] = 2'b00;
      pin_prev  = '0;
      pin_now   = 32'h0000_0001;
      reeval    = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check("R10 mixed A", set_req_a, 32'h0000_0005);
      check("R10 mixed B", {{(NA-NB){1'b0}}, set_req_b}, 32'h0000_0001);

      // R8 persistence over several cycles
      pin_dir = '0; sense_cfg = {NA{2'b01}}; pin_prev = '1; pin_now = '1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R8 repeat A", set_req_a, '1);
      check("R9 gated B", {{(NA-NB){1'b0}}, set_req_b}, '0);

      // R1 asynchronous clear mid-run
      rst_n = 1'b0;
      #1;
      check("R1 async clear A", set_req_a, '0);
      rst_n = 1'b1;

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule